// File: doc/BRIEF.md
# Keyed One-Time-Programmable Fuse Controller

This block is a memory-mapped register slave that fronts a small one-time-programmable fuse array, modelled as a synthesizable register array. Software reaches it through 32-bit word accesses with byte addresses and a request/response handshake. The slave always accepts a request, and every accepted request is answered one cycle later.

There are two ways in. A read-only window returns any fuse word directly. A keyed command register starts a protected read or a program operation on one word. The command must carry the correct unlock key. It runs for a fixed number of cycles, and its command bit stays set until the operation ends. A protected read leaves the fetched word in a result register. A program operation ORs a staged data word into the addressed fuse word, so a fuse bit can go from 0 to 1 but never back. Software reads a multi-word field by issuing one protected read per 4-byte step. Byte n of a field sits in bits 8n+7:8n of its word, little-endian.

Top module: `fuse_keyed_ctrl`

## Requirements
- R1: After reset, every register, every window word and the command status read as zero, and `req_ready` is high.
- R2: A write to the command register (offset 0x40) starts an operation only when bits 15:8 equal 0xAC. With any other key, no operation starts and no fuse word changes.
- R3: A keyed write with bit 1 set starts a protected read of the word selected by bits 23:16. Bit 1 of the command register reads 1 for LAT cycles, then clears, and the fetched word then reads from the result register at offset 0x60. Bits 23:16 of the command register read back the byte offset of the last accepted command.
- R4: A keyed write with bit 0 set (bit 1 clear) captures the staging register at offset 0x50. After LAT cycles it ORs that word into the addressed fuse word, and bit 0 then clears.
- R5: A command-register write made while an operation is busy is ignored. This includes a write made in the operation's final cycle.
- R6: A read at offset 0x200 + 4k returns fuse word k directly, for k from 0 to 63.
- R7: Writes to the result register and to the window leave them unchanged. Reads of unmapped offsets return zero.
- R8: The two low bits of the byte offset are ignored when selecting the word. When bits 1 and 0 are both set, only a read is performed.
- R9: Each accepted request gives `rsp_valid` exactly one cycle later, and there is no response without a request. `rsp_rdata` is zero whenever `rsp_valid` is low. The staging register reads back what was written to it.
- R10: A window read accepted in the same cycle that a program operation commits returns the fuse word as it was before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Byte address; low two bits ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and when idle |

## Verification
Two functions can fall in the same cycle. One is a program operation committing its OR into a fuse word. The other is a bus access touching that same word, either a window read or a new command write. The bench starts a program operation, counts LAT-1 idle cycles, and then presents the access in the commit cycle itself. It expects the window read to return the pre-commit word, and it expects the command write to leave no trace in the command status or offset field. A behavioural model running every clock judges all the other responses, and it is independent of the design's structure.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    localparam int CTRL_OFF  = 'h40;
    localparam int STAGE_OFF = 'h50;
    localparam int RES_OFF   = 'h60;
    localparam int WIN_BASE  = 'h200;
    localparam logic [7:0] UNLOCK = 8'hAC;

    typedef struct packed {
        logic [31:0] stage;
        logic [31:0] result;
        logic        rsp_v;
        logic [31:0] rsp_d;
    } bus_state_t;
endpackage

// File: rtl/fuse_store.sv
module fuse_store #(
    parameter int WORDS = 64,
    parameter int WA    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic [WA-1:0] prog_word,
    input  logic [31:0]   prog_data,
    input  logic [WA-1:0] win_word,
    output logic [31:0]   win_data,
    input  logic [WA-1:0] op_word,
    output logic [31:0]   op_data
);
    logic [31:0] word_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [31:0] cell_d;
        always_comb begin
            cell_d = word_q[i];
            if (prog_en && prog_word == WA'(i))
                cell_d = word_q[i] | prog_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[i] <= '0;
            else        word_q[i] <= cell_d;
        end
    end

    assign win_data = word_q[win_word];
    assign op_data  = word_q[op_word];
endmodule

// File: rtl/fuse_cmd_engine.sv
module fuse_cmd_engine #(
    parameter int LAT = 8,
    parameter int WA  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_key,
    input  logic [7:0]    cmd_off,
    input  logic [1:0]    cmd_bits,
    input  logic [31:0]   stage_data,
    output logic          busy_rd,
    output logic          busy_wr,
    output logic [7:0]    cur_off,
    output logic          fin_rd,
    output logic          fin_wr,
    output logic [WA-1:0] op_word,
    output logic [31:0]   op_wdata
);
    import fuse_pkg::*;
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [CW-1:0] cnt;
        logic [7:0]    off;
        logic [31:0]   data;
    } eng_t;

    eng_t s_d, s_q;
    logic busy, last;

    assign busy = s_q.rd | s_q.wr;
    assign last = busy && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (busy) begin
            if (last) begin
                s_d.rd = 1'b0;
                s_d.wr = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (cmd_we && !busy && cmd_key == UNLOCK && cmd_bits != 2'b00) begin
            s_d.rd   = cmd_bits[1];
            s_d.wr   = ~cmd_bits[1];
            s_d.cnt  = CW'(LAT - 1);
            s_d.off  = cmd_off;
            s_d.data = stage_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_rd  = s_q.rd;
    assign busy_wr  = s_q.wr;
    assign cur_off  = s_q.off;
    assign fin_rd   = last && s_q.rd;
    assign fin_wr   = last && s_q.wr;
    assign op_word  = s_q.off[WA+1:2];
    assign op_wdata = s_q.data;
endmodule

// File: rtl/fuse_keyed_ctrl.sv
module fuse_keyed_ctrl #(
    parameter int AW    = 12,
    parameter int WORDS = 64,
    parameter int LAT   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata
);
    import fuse_pkg::*;
    localparam int WA = $clog2(WORDS);
    localparam logic [AW-1:0] WIN_LO = AW'(WIN_BASE);
    localparam logic [AW-1:0] WIN_HI = AW'(WIN_BASE + 4 * WORDS);

    bus_state_t st_d, st_q;
    logic [AW-1:0] a;
    logic          win_hit, cmd_we;
    logic          busy_rd, busy_wr, fin_rd, fin_wr;
    logic [7:0]    cur_off;
    logic [WA-1:0] op_word;
    logic [31:0]   op_wdata, op_rdata, win_data;
    logic          unused_addr_lsb;

    assign a               = {req_addr[AW-1:2], 2'b00};
    assign unused_addr_lsb = ^req_addr[1:0];
    assign win_hit         = (a >= WIN_LO) && (a < WIN_HI);
    assign cmd_we          = req_valid && req_write && (a == AW'(CTRL_OFF));
    assign req_ready       = 1'b1;

    fuse_cmd_engine #(.LAT(LAT), .WA(WA)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_key(req_wdata[15:8]), .cmd_off(req_wdata[23:16]),
        .cmd_bits(req_wdata[1:0]), .stage_data(st_q.stage),
        .busy_rd(busy_rd), .busy_wr(busy_wr), .cur_off(cur_off),
        .fin_rd(fin_rd), .fin_wr(fin_wr), .op_word(op_word), .op_wdata(op_wdata)
    );

    fuse_store #(.WORDS(WORDS), .WA(WA)) u_store (
        .clk(clk), .rst_n(rst_n),
        .prog_en(fin_wr), .prog_word(op_word), .prog_data(op_wdata),
        .win_word(a[WA+1:2]), .win_data(win_data),
        .op_word(op_word), .op_data(op_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = req_valid;
        st_d.rsp_d = '0;
        if (req_valid && !req_write) begin
            if (a == AW'(CTRL_OFF))
                st_d.rsp_d = {8'h00, cur_off, 8'h00, 6'b0, busy_rd, busy_wr};
            else if (a == AW'(STAGE_OFF))
                st_d.rsp_d = st_q.stage;
            else if (a == AW'(RES_OFF))
                st_d.rsp_d = st_q.result;
            else if (win_hit)
                st_d.rsp_d = win_data;
        end
        if (req_valid && req_write && a == AW'(STAGE_OFF))
            st_d.stage = req_wdata;
        if (fin_rd)
            st_d.result = op_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rsp_d;
endmodule

// File: rtl/fuse_keyed_ctrl_chk.sv
module fuse_keyed_ctrl_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [31:0]   req_wdata,
    input logic          rsp_valid,
    input logic [31:0]   rsp_rdata,
    input logic          busy_rd,
    input logic          busy_wr,
    input logic [7:0]    cur_off
);
    logic ctrl_wr;
    assign ctrl_wr = req_valid && req_write && ({req_addr[AW-1:2], 2'b00} == AW'('h40));

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_rdata == 32'h0);
    // R8
    single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_rd && busy_wr));
    // R2
    bad_key_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && req_wdata[15:8] != 8'hAC && !busy_rd && !busy_wr) |=> (!busy_rd && !busy_wr));
    // R5
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (busy_rd || busy_wr)) |=> $stable(cur_off));
endmodule

bind fuse_keyed_ctrl fuse_keyed_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy_rd(busy_rd), .busy_wr(busy_wr), .cur_off(cur_off)
);

// File: tb/fuse_keyed_ctrl_bench.sv
module fuse_keyed_ctrl_bench;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;

    int total = 0, bad = 0, cycles = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    fuse_keyed_ctrl u_fuse_keyed_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // behavioural reference
    int unsigned m_mem[64];
    bit          m_busy, m_isw;
    int          m_cnt;
    int unsigned m_off, m_stage, m_cap, m_res;
    bit          exp_v;
    int unsigned exp_d;

    function automatic int unsigned model_read(int unsigned addr);
        int unsigned aa = addr & 32'hFFC;
        if (aa == 'h40) return (m_off << 16) | ((m_busy && !m_isw) ? 2 : 0) | ((m_busy && m_isw) ? 1 : 0);
        if (aa == 'h50) return m_stage;
        if (aa == 'h60) return m_res;
        if (aa >= 'h200 && aa < 'h300) return m_mem[(aa - 'h200) >> 2];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_busy = 0; m_isw = 0; m_cnt = 0; m_off = 0; m_stage = 0; m_cap = 0; m_res = 0;
            exp_v = 0; exp_d = 0;
        end else begin
            bit pre_busy;
            exp_v = req_valid;
            exp_d = (req_valid && !req_write) ? model_read(req_addr) : 0;
            pre_busy = m_busy;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    if (m_isw) m_mem[(m_off >> 2) & 63] |= m_cap;
                    else       m_res = m_mem[(m_off >> 2) & 63];
                    m_busy = 0;
                end else m_cnt--;
            end
            if (req_valid && req_write) begin
                if ((req_addr & 12'hFFC) == 'h40) begin
                    if (!pre_busy && req_wdata[15:8] == 8'hAC && req_wdata[1:0] != 0) begin
                        m_busy = 1; m_isw = !req_wdata[1]; m_cnt = LAT - 1;
                        m_off = req_wdata[23:16]; m_cap = m_stage;
                    end
                end else if ((req_addr & 12'hFFC) == 'h50) m_stage = req_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (rsp_valid !== exp_v || rsp_rdata !== exp_d) begin
                bad++;
                $display("FAIL %s model compare: got v=%0b d=%h expected v=%0b d=%h",
                         cur_tag, rsp_valid, rsp_rdata, exp_v, exp_d);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 40; i++) begin
            rd(12'h040, v);
            if (v[1:0] == 2'b00) break;
        end
    endtask

    function automatic logic [31:0] cmd(logic [7:0] off, logic [7:0] key, logic [1:0] bits);
        return {8'h00, off, key, 6'b0, bits};
    endfunction

    initial begin
        logic [31:0] v;
        logic [31:0] lf = 32'h1D2C3B4A;
        repeat (3) @(negedge clk);
        rst_n = 1;

        cur_tag = "R1";
        chk("R1 ready", {31'b0, req_ready}, 32'h1);
        rd(12'h040, v); chk("R1 ctrl", v, 0);
        rd(12'h050, v); chk("R1 stage", v, 0);
        rd(12'h060, v); chk("R1 result", v, 0);
        rd(12'h200, v); chk("R1 win0", v, 0);
        rd(12'h2FC, v); chk("R1 win63", v, 0);

        cur_tag = "R9";
        wr(12'h050, 32'h0000_00A5);
        rd(12'h050, v); chk("R9 stage readback", v, 32'hA5);

        cur_tag = "R2";
        wr(12'h040, cmd(8'h08, 8'h53, 2'b01));
        rd(12'h040, v); chk("R2 bad key no busy", v[1:0], 0);
        repeat (LAT + 2) @(negedge clk);
        rd(12'h208, v); chk("R2 bad key no program", v, 0);

        cur_tag = "R4";
        wr(12'h040, cmd(8'h08, 8'hAC, 2'b01));
        rd(12'h040, v); chk("R4 write bit busy", v[1:0], 2'b01);
        wait_idle();
        rd(12'h040, v); chk("R4 write bit cleared", v[1:0], 0);
        rd(12'h208, v); chk("R4 programmed", v, 32'hA5);
        wr(12'h050, 32'h0000_5A00);
        wr(12'h040, cmd(8'h08, 8'hAC, 2'b01)); wait_idle();
        rd(12'h208, v); chk("R4 OR accumulate", v, 32'h5AA5);
        wr(12'h050, 32'h0);
        wr(12'h040, cmd(8'h08, 8'hAC, 2'b01)); wait_idle();
        rd(12'h208, v); chk("R4 zero keeps bits", v, 32'h5AA5);

        cur_tag = "R3";
        wr(12'h040, cmd(8'h08, 8'hAC, 2'b10));
        rd(12'h040, v); chk("R3 read bit busy", v[1:0], 2'b10);
        chk("R3 offset field", v[23:16], 8'h08);
        wait_idle();
        rd(12'h060, v); chk("R3 result", v, 32'h5AA5);

        cur_tag = "R8";
        wr(12'h040, cmd(8'h00, 8'hAC, 2'b10)); wait_idle();
        rd(12'h060, v); chk("R8 word0 read", v, 0);
        wr(12'h040, cmd(8'h0B, 8'hAC, 2'b10)); wait_idle();
        rd(12'h060, v); chk("R8 low bits ignored", v, 32'h5AA5);
        wr(12'h050, 32'hFFFF);
        wr(12'h040, cmd(8'h0C, 8'hAC, 2'b11));
        rd(12'h040, v); chk("R8 both bits read only", v[1:0], 2'b10);
        wait_idle();
        rd(12'h20C, v); chk("R8 both bits no program", v, 0);
        rd(12'h060, v); chk("R8 both bits read result", v, 0);

        cur_tag = "R5";
        wr(12'h050, 32'h1111);
        wr(12'h040, cmd(8'h10, 8'hAC, 2'b01));
        wr(12'h040, cmd(8'h08, 8'hAC, 2'b10));
        rd(12'h040, v); chk("R5 busy cmd ignored offset", v[23:16], 8'h10);
        wait_idle();
        rd(12'h060, v); chk("R5 busy cmd ignored result", v, 0);
        rd(12'h210, v); chk("R5 program done", v, 32'h1111);

        cur_tag = "R7";
        wr(12'h060, 32'hDEAD);
        rd(12'h060, v); chk("R7 result write ignored", v, 0);
        wr(12'h210, 32'hFFFF_FFFF);
        rd(12'h210, v); chk("R7 window write ignored", v, 32'h1111);
        rd(12'h044, v); chk("R7 unmapped 0x44", v, 0);
        rd(12'h300, v); chk("R7 unmapped 0x300", v, 0);
        rd(12'h100, v); chk("R7 unmapped 0x100", v, 0);

        cur_tag = "R10";
        wr(12'h050, 32'h00F0);
        wr(12'h040, cmd(8'h14, 8'hAC, 2'b01));
        repeat (LAT - 2) @(negedge clk);
        rd(12'h214, v); chk("R10 commit-cycle read old", v, 0);
        rd(12'h214, v); chk("R10 next read new", v, 32'h00F0);

        cur_tag = "R5";
        wr(12'h050, 32'h0F00);
        wr(12'h040, cmd(8'h18, 8'hAC, 2'b01));
        repeat (LAT - 2) @(negedge clk);
        wr(12'h040, cmd(8'h14, 8'hAC, 2'b10));
        rd(12'h040, v); chk("R5 final-cycle cmd ignored bits", v[1:0], 0);
        chk("R5 final-cycle cmd ignored offset", v[23:16], 8'h18);

        cur_tag = "R6";
        rd(12'h218, v); chk("R6 window word6", v, 32'h0F00);
        rd(12'h21A, v); chk("R6 window low bits ignored", v, 32'h0F00);

        cur_tag = "R3";
        wr(12'h040, cmd(8'h10, 8'hAC, 2'b10)); wait_idle();
        rd(12'h060, v); chk("R3 step word0", v, 32'h1111);
        wr(12'h040, cmd(8'h14, 8'hAC, 2'b10)); wait_idle();
        rd(12'h060, v); chk("R3 step word1", v, 32'h00F0);

        cur_tag = "R4";
        for (int k = 0; k < 16; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            wr(12'h050, lf & 32'h0101_0101 << (k % 7));
            wr(12'h040, cmd({lf[7:2], 2'b00}, 8'hAC, 2'b01)); wait_idle();
            wr(12'h040, cmd({lf[7:2], 2'b00}, 8'hAC, 2'b10)); wait_idle();
            rd(12'h060, v);
            rd(12'h200 + {4'h0, lf[7:2], 2'b00}, v);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule